// File: doc/BRIEF.md
# Single-Line Trigger-Configurable Interrupt Controller

This block takes one asynchronous external interrupt pin, brings it into the core clock domain, and turns it into a sticky pending flag. The flag is set according to a two-bit trigger selection: active-low level, falling edge, active-high level or rising edge. The request to the parent interrupt controller is raised while the flag is set and the request is enabled. Software configures and services the line through three 32-bit registers on a simple word-addressed read/write port: a trigger-select register, a pending register that is cleared by writing a one, and an enable register.

A build-time parameter chooses between two address maps for these three registers, so the same RTL can sit behind either decode. Software acknowledges the flag after handling the interrupt. In the level modes the flag sets again straight away if the pin is still active.

Top module: `irq_line_ctrl`

## Requirements
- R1: The pin passes through a two-flop synchronizer. A change on `irq_i` shows in the pending flag after the third rising clock edge that follows it, and not after the second.
- R2: Trigger register bits [1:0] select the mode: 0 is active-low level, 1 is falling edge, 2 is active-high level, 3 is rising edge.
- R3: In a level mode the pending flag sets on every cycle in which the synchronized pin is at its active level, so an acknowledge does not clear it while the pin stays active.
- R4: In an edge mode, one transition of the selected direction sets the flag once. After an acknowledge it stays clear while the pin holds its level.
- R5: Writing a word with bit 0 set to the pending register clears the flag. A write with bit 0 clear leaves the flag unchanged.
- R6: If an acknowledge write and a new event fall in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the pending flag and enable bit 0 are both set. The flag still latches events while the enable bit is clear.
- R8: After reset the trigger, pending and enable registers read 0 and `irq_o` is low.
- R9: With `ALT_MAP` = 0, trigger, pending and enable sit at byte addresses 0x00, 0x04 and 0x08.
- R10: With `ALT_MAP` = 1, trigger, pending and enable sit at byte addresses 0x0C, 0x10 and 0x40.
- R11: Register bits that are not defined read as 0. Reads of unmapped addresses return 0, and writes to them change nothing.
- R12: The trigger mode changes only on a write to the trigger register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt pin, asynchronous |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while `req_i` is high and `we_i` is low |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The properties assume that a register write is presented as one cycle of stable `req_i`, `we_i`, `addr_i` and `wdata_i` around a rising edge, and that `irq_i` changes are only seen through the synchronizer, so they reason about the synchronized level and the derived event rather than the raw pin. The stimulus changes the pin and the bus signals only on falling clock edges and holds write strobes for exactly one rising edge. Random trigger values, acknowledges and pin toggles are therefore all legal, while directed sequences place an acknowledge on the exact cycle in which an edge is detected.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_HIGH_LVL = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic [7:0] trig;
    logic [7:0] pend;
    logic [7:0] en;
  } reg_map_t;

  localparam reg_map_t MAP_STD = '{trig: 8'h00, pend: 8'h04, en: 8'h08};
  localparam reg_map_t MAP_ALT = '{trig: 8'h0C, pend: 8'h10, en: 8'h40};

  function automatic reg_map_t pick_map(input bit alt);
    return alt ? MAP_ALT : MAP_STD;
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect
  import irq_line_pkg::*;
#(
  parameter bit RST_VAL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  trig_mode_e mode_i,
  output logic       evt_o
);

  logic prev_q;
  logic act_now, act_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sync_i;
  end

  // mode[1] picks the active polarity, mode[0] picks edge over level
  assign act_now  = (sync_i ~^ mode_i[1]);
  assign act_prev = (prev_q ~^ mode_i[1]);

  always_comb begin
    if (mode_i[0]) evt_o = act_now & ~act_prev;
    else           evt_o = act_now;
  end

endmodule

// File: rtl/irq_line_regs.sv
module irq_line_regs
  import irq_line_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output trig_mode_e        mode_o,
  output logic              pend_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam reg_map_t MAP = pick_map(ALT_MAP);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(MAP.trig);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(MAP.pend);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(MAP.en);

  trig_mode_e mode_q;
  logic pend_q, en_q;
  logic hit_trig, hit_pend, hit_en;
  logic wr, ack;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:2];

  assign hit_trig = req_i && (addr_i == A_TRIG);
  assign hit_pend = req_i && (addr_i == A_PEND);
  assign hit_en   = req_i && (addr_i == A_EN);
  assign wr       = req_i && we_i;
  assign ack      = wr && hit_pend && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TRIG_LOW_LVL;
      en_q   <= 1'b0;
    end else begin
      if (wr && hit_trig) mode_q <= trig_mode_e'(wdata_i[1:0]);
      if (wr && hit_en)   en_q   <= wdata_i[0];
    end
  end

  // a fresh event outranks a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt_i | (pend_q & ~ack);
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_trig) rdata_o[1:0] = mode_q;
      if (hit_pend) rdata_o[0]   = pend_q;
      if (hit_en)   rdata_o[0]   = en_q;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit ALT_MAP     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  // idle-high reset value keeps the default active-low mode quiet
  localparam bit IDLE_LVL = 1'b1;

  logic       sync_q;
  logic       evt;
  logic       pend;
  logic       en;
  trig_mode_e mode;

  irq_line_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(IDLE_LVL)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (sync_q)
  );

  irq_line_detect #(
    .RST_VAL(IDLE_LVL)
  ) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_q),
    .mode_i(mode),
    .evt_o (evt)
  );

  irq_line_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ALT_MAP(ALT_MAP)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .mode_o (mode),
    .pend_o (pend),
    .en_o   (en),
    .rdata_o(rdata_o)
  );

  assign irq_o = pend & en;

endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk
  import irq_line_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sync_q,
  input logic              evt,
  input logic              pend,
  input trig_mode_e        mode
);

  localparam reg_map_t MAP = pick_map(ALT_MAP);

  logic ack_wr, trig_wr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];
  assign ack_wr  = req_i && we_i && (addr_i == ADDR_W'(MAP.pend)) && wdata_i[0];
  assign trig_wr = req_i && we_i && (addr_i == ADDR_W'(MAP.trig));

  assert_pend_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> $past(evt));

  assert_level_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TRIG_HIGH_LVL && sync_q) |=> pend);

  assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !evt) |=> !pend);

  assert_pend_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_wr && !evt && pend) |=> pend);

  assert_evt_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> pend);

  assert_mode_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_wr |=> $stable(mode));

endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ALT_MAP(ALT_MAP)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .sync_q (sync_q),
  .evt    (evt),
  .pend   (pend),
  .mode   (mode)
);

// File: tb/irq_line_ctrl_bench.sv
`timescale 1ns/100ps
module irq_line_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_a = 1'b1, irq_b = 1'b1;
  logic          req_a = 1'b0, req_b = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic          irq_o_a, irq_o_b;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_MAP(1'b0)) u_irq_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_a), .req_i(req_a), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_a), .irq_o(irq_o_a));

  irq_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_MAP(1'b1)) u_irq_line_ctrl_alt (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_b), .req_i(req_b), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_b), .irq_o(irq_o_b));

  // reference model for the standard map, built from the requirements
  logic       m_s1, m_s2, m_prev, m_pend, m_en;
  logic [1:0] m_mode;

  function automatic logic exp_evt(input logic [1:0] md, input logic cur, input logic prv);
    case (md)
      2'd0:    return !cur;
      2'd1:    return prv && !cur;
      2'd2:    return cur;
      default: return !prv && cur;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      8'h00:   return {30'd0, m_mode};
      8'h04:   return {31'd0, m_pend};
      8'h08:   return {31'd0, m_en};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
      m_mode <= 2'd0; m_pend <= 1'b0; m_en <= 1'b0;
    end else begin
      m_s1   <= irq_a;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_pend <= exp_evt(m_mode, m_s2, m_prev) |
                (m_pend & !(req_a && we && addr == 8'h04 && wdata[0]));
      if (req_a && we && addr == 8'h00) m_mode <= wdata[1:0];
      if (req_a && we && addr == 8'h08) m_en   <= wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input bit alt, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_a = !alt; req_b = alt; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [AW-1:0] a, output logic [DW-1:0] d);
    req_a = !alt; req_b = alt; we = 1'b0; addr = a;
    #1;
    d = alt ? rd_b : rd_a;
    req_a = 1'b0; req_b = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h1234_5678));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R8 reset state
    rd(0, 8'h00, v); chk("R8 trig", v, 0);
    rd(0, 8'h04, v); chk("R8 pend", v, 0);
    rd(0, 8'h08, v); chk("R8 en", v, 0);
    chk("R8 irq_o", irq_o_a, 0);

    // R11 undefined bits and unmapped addresses, R9 map
    wr(0, 8'h08, 32'hFFFF_FFFF);
    rd(0, 8'h08, v); chk("R11 en bits", v, 1);
    wr(0, 8'h00, 32'hFFFF_FFFF);
    rd(0, 8'h00, v); chk("R11 trig bits / R9", v, 3);
    wr(0, 8'h0C, 32'h0);
    rd(0, 8'h00, v); chk("R11 unmapped write", v, 3);
    rd(0, 8'h40, v); chk("R11 unmapped read", v, 0);

    // R1 latency and R4 rising edge
    irq_a = 1'b0; wait_cyc(4);
    rd(0, 8'h04, v); chk("R4 fall ignored in rise mode", v, 0);
    irq_a = 1'b1; wait_cyc(2);
    rd(0, 8'h04, v); chk("R1 not after second edge", v, 0);
    wait_cyc(1);
    rd(0, 8'h04, v); chk("R1 after third edge", v, 1);
    chk("R7 irq_o enabled", irq_o_a, 1);

    // R5 write-one-to-clear
    wr(0, 8'h04, 32'hFFFF_FFFE);
    rd(0, 8'h04, v); chk("R5 zero write keeps", v, 1);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R5 one clears", v, 0);
    wait_cyc(5);
    rd(0, 8'h04, v); chk("R4 stays clear while held", v, 0);

    // R6 ack on the detection cycle
    irq_a = 1'b0; wait_cyc(4);
    irq_a = 1'b1; wait_cyc(2);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R6 event beats ack", v, 1);
    wr(0, 8'h04, 32'h1);

    // R2 falling edge
    wr(0, 8'h00, 32'h1);
    irq_a = 1'b0; wait_cyc(3);
    rd(0, 8'h04, v); chk("R2 falling edge", v, 1);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R4 falling single event", v, 0);

    // R3 active-low level
    wr(0, 8'h00, 32'h0);
    wait_cyc(1);
    rd(0, 8'h04, v); chk("R2 low level", v, 1);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R3 low level resets", v, 1);

    // R3 active-high level
    irq_a = 1'b1;
    wr(0, 8'h00, 32'h2);
    wait_cyc(4);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R3 high level resets", v, 1);
    irq_a = 1'b0; wait_cyc(3);
    wr(0, 8'h04, 32'h1);
    rd(0, 8'h04, v); chk("R3 cleared when inactive", v, 0);

    // R7 gating with latch while disabled
    wr(0, 8'h08, 32'h0);
    irq_a = 1'b1; wait_cyc(3);
    rd(0, 8'h04, v); chk("R7 latches while disabled", v, 1);
    chk("R7 irq_o gated", irq_o_a, 0);
    wr(0, 8'h08, 32'h1);
    chk("R7 irq_o released", irq_o_a, 1);

    // R10 alternate map
    rd(1, 8'h0C, v); chk("R10 trig reset", v, 0);
    wr(1, 8'h0C, 32'h2);
    rd(1, 8'h0C, v); chk("R10 trig at 0x0C", v, 2);
    rd(1, 8'h00, v); chk("R10 0x00 unmapped", v, 0);
    wait_cyc(1);
    rd(1, 8'h10, v); chk("R10 pend at 0x10", v, 1);
    chk("R10 irq_o before enable", irq_o_b, 0);
    wr(1, 8'h40, 32'h1);
    rd(1, 8'h40, v); chk("R10 en at 0x40", v, 1);
    chk("R10 irq_o enabled", irq_o_b, 1);
    wr(1, 8'h0C, 32'h0);
    wr(1, 8'h10, 32'h1);
    rd(1, 8'h10, v); chk("R10 ack at 0x10", v, 0);
    chk("R10 irq_o cleared", irq_o_b, 0);

    // random phase against the model, R1 R2 R5 R7 R12
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [AW-1:0] a;
      chk("R7 random irq_o", irq_o_a, m_pend & m_en);
      if ($urandom_range(3) == 0) irq_a = ~irq_a;
      op = $urandom_range(3);
      case ($urandom_range(4))
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h0C;
        default: a = 8'h10;
      endcase
      if (op == 0) begin
        wr(0, a, $urandom());
      end else if (op == 1) begin
        rd(0, a, v);
        chk("R12 random readback", v, exp_rd(a));
        wait_cyc(1);
      end else begin
        wait_cyc(1);
      end
    end

    finish_run();
  end

endmodule